// File: doc/BRIEF.md
# GPIO Controller with Change Interrupts

A register-mapped controller for a parameterised number of general-purpose lines (up to 32). Software reaches six 32-bit word registers over a simple request bus:
- line direction;
- line data;
- interrupt enable;
- change status;
- write mask;
- interrupt type.

Each line drives an output value and an output enable toward the pad. Its pad level comes back through a two-stage synchronizer.

A line whose synchronized level moves in either direction latches a sticky change bit. The interrupt output stays high while any latched change bit has its enable bit set. Software acknowledges a change by writing 1 to its status bit. The write mask limits which direction and data bits a write may alter.

A two-state bus sequencer handles the read responses:
- `BUS_IDLE` is the rest state.
- A read request moves it to `BUS_RESP` (transition *take-read*). There it presents the registered read data with a valid strobe.
- From `BUS_RESP`, a further read request keeps it in `BUS_RESP` (transition *chain-read*).
- Any other input returns it to `BUS_IDLE` (transition *release*).

Writes take effect at the clock edge that samples them, in either state.

Top module: `gpio_chg_ctrl`

## Requirements
- R1: After reset, the registers hold these values: direction, output data, interrupt enable and change status are zero, and the write mask is all ones over the implemented lines. In addition, `pin_oe_o`, `pin_o`, `irq_o` and `rvalid_o` are low.
- R2: Registers are selected by byte offset:
  - 0x00 direction
  - 0x04 data
  - 0x08 interrupt enable
  - 0x0C change status
  - 0x10 write mask
  - 0x14 interrupt type

  Any other offset reads zero. The read data appears on `rdata_o` with `rvalid_o` high in the cycle after the request is sampled.
- R3: A direction bit of 1 makes the line an output. `pin_oe_o` follows the direction register, and `pin_o` follows the output data register.
- R4: A data read returns, per line, the output register bit when the line is an output and the synchronized pad level when it is an input. Bits at and above NUM_LINES read zero in every register.
- R5: A rising or falling move of a pad level sets that line's change bit. The bit is readable, and acts on `irq_o`, by the third clock edge after the pad changes.
- R6: Change bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: A change detected in the same cycle as a write-1 acknowledge of that bit leaves the bit set.
- R8: `irq_o` is high exactly when some change bit is set with its enable bit set. Clearing an enable bit masks that line.
- R9: On a write, a direction or output data bit changes only where the write-mask bit is 1. The enable, status and mask registers are not limited by the mask.
- R10: The interrupt-type register reads ones for every implemented line, meaning both-edge detection. Writes to it have no effect.
- R11: Back-to-back read requests each produce one valid response, in order, in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Bus request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe |
| pin_i | input | NUM_LINES | Pad levels (asynchronous) |
| pin_o | output | NUM_LINES | Output values toward the pads |
| pin_oe_o | output | NUM_LINES | Per-line output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the controller with NUM_LINES set to 12, not the default 32. With that setting, writes carrying ones in bits 12 to 31 must be dropped, and the read-back of every register, including the constant interrupt-type value, must show zeros there. A narrow line count also lets the tests use a handful of input and output lines at once: mixed-direction data reads, a masked write that touches only the low nibble, and an acknowledge that races a fresh edge.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_DATA,
        SEL_IEN,
        SEL_STAT,
        SEL_WMSK,
        SEL_TYPE,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

    localparam int REG_DIR_OFS  = 'h00;
    localparam int REG_DATA_OFS = 'h04;
    localparam int REG_IEN_OFS  = 'h08;
    localparam int REG_STAT_OFS = 'h0C;
    localparam int REG_WMSK_OFS = 'h10;
    localparam int REG_TYPE_OFS = 'h14;

endpackage

// File: rtl/gpio_chg_edge.sv
module gpio_chg_edge #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] pin_i,
    output logic [NUM_LINES-1:0] level_o,
    output logic [NUM_LINES-1:0] chg_o
);

    // Per line: two synchronizer stages and one history flop.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level_o[g] = sync_q;
        assign chg_o[g]   = sync_q ^ prev_q;   // rising or falling
    end

endmodule

// File: rtl/gpio_chg_bus_fsm.sv
module gpio_chg_bus_fsm
    import gpio_chg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic wr_i,
    output logic rd_take_o,
    output logic wr_take_o,
    output logic rvalid_o
);

    bus_state_e state_q;
    bus_state_e state_d;
    logic       rd_req;

    assign rd_req = req_i && !wr_i;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req) state_d = BUS_RESP;   // take-read
            BUS_RESP: if (!rd_req) state_d = BUS_IDLE;  // release (else chain-read)
            default:  state_d = BUS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= BUS_IDLE;
        else         state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        rd_take_o = rd_req;
        wr_take_o = req_i && wr_i;
        rvalid_o  = 1'b0;
        unique case (state_q)
            BUS_IDLE: rvalid_o = 1'b0;
            BUS_RESP: rvalid_o = 1'b1;
            default:  rvalid_o = 1'b0;
        endcase
    end

    // R11 / R2: each sampled read gives a response one cycle later.
    p_read_resp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !wr_i) |=> rvalid_o);

    // R2: no response without a read.
    p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_i && !wr_i) |=> !rvalid_o);

endmodule

// File: rtl/gpio_chg_ctrl.sv
module gpio_chg_ctrl
    import gpio_chg_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_i,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    output logic                 rvalid_o,
    input  logic [NUM_LINES-1:0] pin_i,
    output logic [NUM_LINES-1:0] pin_o,
    output logic [NUM_LINES-1:0] pin_oe_o,
    output logic                 irq_o
);

    localparam int DW = 32;
    localparam logic [NUM_LINES-1:0] LINES_ONES = '1;

    function automatic logic [DW-1:0] widen(input logic [NUM_LINES-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        r[NUM_LINES-1:0] = v;
        return r;
    endfunction

    logic                 rd_take;
    logic                 wr_take;
    reg_sel_e             sel;
    logic [NUM_LINES-1:0] wdat;
    logic [NUM_LINES-1:0] level;
    logic [NUM_LINES-1:0] chg;
    logic [NUM_LINES-1:0] stat_clr;

    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] dout_q;
    logic [NUM_LINES-1:0] ien_q;
    logic [NUM_LINES-1:0] stat_q;
    logic [NUM_LINES-1:0] wmsk_q;
    logic [DW-1:0]        rmux;
    logic [DW-1:0]        rdata_q;

    gpio_chg_bus_fsm u_bus (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req_i),
        .wr_i     (wr_i),
        .rd_take_o(rd_take),
        .wr_take_o(wr_take),
        .rvalid_o (rvalid_o)
    );

    gpio_chg_edge #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .level_o(level),
        .chg_o  (chg)
    );

    // Offset decode.
    always_comb begin
        if      (addr_i == ADDR_W'(REG_DIR_OFS))  sel = SEL_DIR;
        else if (addr_i == ADDR_W'(REG_DATA_OFS)) sel = SEL_DATA;
        else if (addr_i == ADDR_W'(REG_IEN_OFS))  sel = SEL_IEN;
        else if (addr_i == ADDR_W'(REG_STAT_OFS)) sel = SEL_STAT;
        else if (addr_i == ADDR_W'(REG_WMSK_OFS)) sel = SEL_WMSK;
        else if (addr_i == ADDR_W'(REG_TYPE_OFS)) sel = SEL_TYPE;
        else                                      sel = SEL_NONE;
    end

    assign wdat     = wdata_i[NUM_LINES-1:0];
    assign stat_clr = (wr_take && sel == SEL_STAT) ? wdat : '0;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dir_q  <= '0;
            dout_q <= '0;
            ien_q  <= '0;
            stat_q <= '0;
            wmsk_q <= LINES_ONES;
        end else begin
            if (wr_take && sel == SEL_DIR)
                dir_q <= (dir_q & ~wmsk_q) | (wdat & wmsk_q);
            if (wr_take && sel == SEL_DATA)
                dout_q <= (dout_q & ~wmsk_q) | (wdat & wmsk_q);
            if (wr_take && sel == SEL_IEN)
                ien_q <= wdat;
            if (wr_take && sel == SEL_WMSK)
                wmsk_q <= wdat;
            // A new change wins over a same-cycle acknowledge.
            stat_q <= (stat_q & ~stat_clr) | chg;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DIR:  rmux = widen(dir_q);
            SEL_DATA: rmux = widen((dir_q & dout_q) | (~dir_q & level));
            SEL_IEN:  rmux = widen(ien_q);
            SEL_STAT: rmux = widen(stat_q);
            SEL_WMSK: rmux = widen(wmsk_q);
            SEL_TYPE: rmux = widen(LINES_ONES);
            default:  rmux = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)      rdata_q <= '0;
        else if (rd_take) rdata_q <= rmux;
    end

    assign rdata_o  = rdata_q;
    assign pin_o    = dout_q;
    assign pin_oe_o = dir_q;
    assign irq_o    = |(stat_q & ien_q);

    // R6: without an acknowledge write, no status bit falls.
    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_take && sel == SEL_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R5 / R7: every detected change is latched, even against an acknowledge.
    p_edge_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chg != '0) |=> ((stat_q & $past(chg)) == $past(chg)));

    // R8: an enabled change raises the interrupt unless the enables are rewritten.
    p_irq_raise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|(chg & ien_q)) && !(wr_take && sel == SEL_IEN)) |=> irq_o);

    // R9: masked direction bits hold across a direction write.
    p_mask_dir_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_take && sel == SEL_DIR) |=> (((dir_q ^ $past(dir_q)) & ~$past(wmsk_q)) == '0));

endmodule

// File: tb/gpio_chg_ctrl_tb.sv
module gpio_chg_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 12;
    localparam int AW         = 5;

    localparam logic [AW-1:0] A_DIR  = 5'h00;
    localparam logic [AW-1:0] A_DATA = 5'h04;
    localparam logic [AW-1:0] A_IEN  = 5'h08;
    localparam logic [AW-1:0] A_STAT = 5'h0C;
    localparam logic [AW-1:0] A_WMSK = 5'h10;
    localparam logic [AW-1:0] A_TYPE = 5'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out;
    logic [NL-1:0] pin_oe;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio_chg_ctrl #(.NUM_LINES(NL), .ADDR_W(AW)) u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .req_i   (req),
        .wr_i    (wr),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .rvalid_o(rvalid),
        .pin_i   (pin_in),
        .pin_o   (pin_out),
        .pin_oe_o(pin_oe),
        .irq_o   (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic rd_pair(input logic [AW-1:0] a0, input logic [31:0] e0,
                           input logic [AW-1:0] a1, input logic [31:0] e1,
                           input string tag);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a0;
        exp_q.push_back(e0); tag_q.push_back(tag);
        @(negedge clk);
        addr = a1;
        exp_q.push_back(e1); tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic set_pins(input logic [NL-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard whenever a response shows.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected response", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 pin_o", 32'(pin_out), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 rvalid", 32'(rvalid), 32'h0);
        rd_reg(A_DIR,  32'h0,   "R1 dir");
        rd_reg(A_DATA, 32'h0,   "R1 data");
        rd_reg(A_IEN,  32'h0,   "R1 ien");
        rd_reg(A_STAT, 32'h0,   "R1 stat");
        rd_reg(A_WMSK, 32'hFFF, "R1 wmask");
        rd_reg(A_TYPE, 32'hFFF, "R10 type");
        rd_reg(5'h18,  32'h0,   "R2 unmapped");
        rd_reg(5'h02,  32'h0,   "R2 misaligned");

        // R3 direction and output drive
        wr_reg(A_DIR, 32'hFFFF_F0F0);
        check("R3 pin_oe", 32'(pin_oe), 32'h0F0);
        wr_reg(A_DATA, 32'hFFFF_FFFF);
        check("R3 pin_o", 32'(pin_out), 32'hFFF);
        rd_reg(A_DIR,  32'h0F0, "R4 dir upper bits zero");
        rd_reg(A_DATA, 32'h0F0, "R4 data mixed, pads low");

        // R4/R5 inputs move high
        set_pins(12'hA05);
        rd_reg(A_DATA, 32'hAF5, "R4 data mixed");
        rd_reg(A_STAT, 32'hA05, "R5 rising edges");
        check("R8 irq masked", 32'(irq), 32'h0);

        // R8 enable and mask
        wr_reg(A_IEN, 32'h001);
        check("R8 irq enabled", 32'(irq), 32'h1);
        wr_reg(A_IEN, 32'h000);
        check("R8 irq masked again", 32'(irq), 32'h0);
        wr_reg(A_IEN, 32'h001);

        // R6 acknowledge
        wr_reg(A_STAT, 32'h004);
        rd_reg(A_STAT, 32'hA01, "R6 clear one bit");
        check("R6 irq stays", 32'(irq), 32'h1);
        wr_reg(A_STAT, 32'h001);
        check("R6 irq after ack", 32'(irq), 32'h0);
        rd_reg(A_STAT, 32'hA00, "R6 sticky others");

        // R5 falling edge
        set_pins(12'hA04);
        check("R5 falling irq", 32'(irq), 32'h1);
        rd_reg(A_STAT, 32'hA01, "R5 falling status");

        // R7 acknowledge racing a new edge on the same line
        @(negedge clk);
        pin_in = 12'hA05;
        @(negedge clk);
        wr_reg(A_STAT, 32'h001);
        rd_reg(A_STAT, 32'hA01, "R7 edge beats ack");
        check("R7 irq", 32'(irq), 32'h1);
        wr_reg(A_STAT, 32'hFFFF_FFFF);
        rd_reg(A_STAT, 32'h0, "R6 clear all");
        check("R6 irq clear all", 32'(irq), 32'h0);

        // R9 write mask
        wr_reg(A_WMSK, 32'h00F);
        rd_reg(A_WMSK, 32'h00F, "R9 mask readback");
        wr_reg(A_DIR, 32'h000);
        rd_reg(A_DIR, 32'h0F0, "R9 masked dir clear");
        wr_reg(A_DIR, 32'h00F);
        rd_reg(A_DIR, 32'h0FF, "R9 masked dir set");
        check("R9 pin_oe", 32'(pin_oe), 32'h0FF);
        wr_reg(A_DATA, 32'h000);
        check("R9 pin_o", 32'(pin_out), 32'hFF0);
        wr_reg(A_IEN, 32'h800);
        rd_reg(A_IEN, 32'h800, "R9 enable not masked");
        wr_reg(A_WMSK, 32'hFFF);

        // R10 type register ignores writes
        wr_reg(A_TYPE, 32'h0);
        rd_reg(A_TYPE, 32'hFFF, "R10 type after write");

        // R11 back-to-back reads
        rd_pair(A_DIR, 32'h0FF, A_IEN, 32'h800, "R11 back-to-back");
        rd_reg(A_DATA, 32'hAF0, "R4 data after mask");

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule